// File: doc/BRIEF.md
# Stereo Cascaded Biquad Equalizer

This block filters a stereo audio stream through a chain of seven second-order IIR sections on each channel. Every left and right sample pair arrives with a one-cycle strobe. The block then runs the pair through the left chain and the right chain one after the other. When both chains are finished, it presents the filtered pair together with a one-cycle done pulse. Each channel has its own coefficients and its own delay history, so the two channels never interact.

All the arithmetic goes through one multiply-accumulate unit. That unit steps over the five taps of every section, first for the left chain and then for the right. A control bus decoder outside the block loads coefficients through a plain write port. Writes land in a staging copy, and the staging copy is moved into the working copy only when a sample is accepted. A bypass input turns an accepted sample into a straight copy of the input, and that sample leaves the filter history unchanged.

Top module: `stereo_biquad_eq`

## Requirements
- R1: Reset has these effects:
  - It clears every section's delay history.
  - It sets every coefficient to an identity section (b0 = 0x100000, all other coefficients 0).
  - It drives `done`, `out_l` and `out_r` to zero.
  - After reset, a filtered sample leaves the block unchanged.
- R2: Each section computes y = b0·x + b1·x[n-1] + b2·x[n-2] − a1·y[n-1] − a2·y[n-2].
  - The coefficients are signed 24-bit values with 20 fraction bits.
  - The sum is kept at full width.
  - The sum is rounded by adding 2^19 and then shifting arithmetically right by 20.
- R3: The sections run in order, 0 through 6, and each section's output feeds the next.
  - `cfg_ch` selects the chain: 0 = left, 1 = right.
  - `cfg_idx` selects the coefficient: 0 = b0, 1 = b1, 2 = b2, 3 = a1, 4 = a2.
  - Each channel keeps its own coefficients and its own history.
- R4: A filtered sample is accepted on the clock edge where `smp_stb` is high and the block is idle.
  - `done` goes high for exactly one cycle on the 84th rising edge after that edge.
  - `out_l` and `out_r` change only on the edge that raises `done`.
- R5: A sample accepted with `bypass` high gives `done` on the next edge, with the outputs equal to the inputs.
  - Such a sample leaves the delay history untouched.
- R6: A coefficient write reaches the filter only at the next accepted sample.
  - A write made while a sample is being computed does not change that sample's result.
- R7: A write with `cfg_sect` ≥ 7 or `cfg_idx` ≥ 5 changes no coefficient.
- R8: A strobe that arrives while a sample is being computed is ignored. It produces no result and no extra `done`.
- R9: Every section output saturates to the signed 32-bit range, 0x7FFFFFFF at the top and 0x80000000 at the bottom.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | Sample pair valid strobe |
| smp_l | input | 32 | Left input sample, signed |
| smp_r | input | 32 | Right input sample, signed |
| bypass | input | 1 | Pass the accepted sample through unfiltered |
| cfg_we | input | 1 | Coefficient write enable |
| cfg_ch | input | 1 | Coefficient channel, 0 left, 1 right |
| cfg_sect | input | 3 | Section index 0–6 |
| cfg_idx | input | 3 | Coefficient index 0–4 (b0,b1,b2,a1,a2) |
| cfg_coef | input | 24 | Coefficient value, signed, 20 fraction bits |
| done | output | 1 | One-cycle pulse when the output pair is valid |
| out_l | output | 32 | Left output sample |
| out_r | output | 32 | Right output sample |

## Verification
The bench steers toward the following corner cases:
- **Rounding ties.** A half gain on ±3 must give 2 and −1. A design that truncated or rounded symmetrically would give 1 or −2.
- **Write timing.** A coefficient written during a computation must not change that result. If it did, the current output would be wrong by a factor of two.
- **Out-of-range writes.** These target addresses that, without a range check, would alias a real coefficient. If the check were missing, a zero would reach the output.
- **Strobes while busy.** An extra strobe must not produce a second result or pull the first one forward.
- **Saturation.** Large gains of both signs must clamp the output at the limits instead of letting it wrap.
- **Bypass in a running IIR stream.** A bypass sample in the middle of a stream with feedback must leave the history alone. If it did not, every later output would drift from the cycle-level model.

// File: rtl/eq_pkg.sv
package eq_pkg;

  // Tap sequence walked by the shared MAC for one section; the final step
  // rounds the sum and updates the section history.
  typedef enum logic [2:0] {
    TAP_B0  = 3'd0,
    TAP_B1  = 3'd1,
    TAP_B2  = 3'd2,
    TAP_A1  = 3'd3,
    TAP_A2  = 3'd4,
    TAP_FIN = 3'd5
  } tap_e;

  localparam int NUM_TAPS = 5;

  function automatic logic tap_is_feedback(tap_e t);
    return (t == TAP_A1) || (t == TAP_A2);
  endfunction

endpackage

// File: rtl/eq_coef_bank.sv
module eq_coef_bank #(
  parameter int SECTIONS  = 7,
  parameter int COEF_W    = 24,
  parameter int COEF_FRAC = 20,
  parameter int SEC_W     = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     wr_en,
  input  logic                     wr_ch,
  input  logic [SEC_W-1:0]         wr_sec,
  input  logic [2:0]               wr_idx,
  input  logic [COEF_W-1:0]        wr_data,
  input  logic                     load,
  input  logic                     rd_ch,
  input  logic [SEC_W-1:0]         rd_sec,
  input  logic [2:0]               rd_idx,
  output logic signed [COEF_W-1:0] rd_data
);
  localparam int NTAP  = eq_pkg::NUM_TAPS;
  localparam int NENT  = 2 * SECTIONS * NTAP;
  localparam int AW    = $clog2(NENT);
  localparam logic signed [COEF_W-1:0] UNITY = COEF_W'(64'd1 << COEF_FRAC);

  // staging copy written by the control port, working copy read by the MAC
  logic signed [COEF_W-1:0] stage_q [NENT];
  logic signed [COEF_W-1:0] work_q  [NENT];

  logic          wr_ok;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;

  assign wr_ok   = wr_en && (int'(wr_sec) < SECTIONS) && (int'(wr_idx) < NTAP);
  assign wr_addr = AW'((int'(wr_ch) * SECTIONS + int'(wr_sec)) * NTAP + int'(wr_idx));
  assign rd_addr = AW'((int'(rd_ch) * SECTIONS + int'(rd_sec)) * NTAP + int'(rd_idx));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NENT; i++) begin
        stage_q[i] <= ((i % NTAP) == 0) ? UNITY : '0;
        work_q[i]  <= ((i % NTAP) == 0) ? UNITY : '0;
      end
    end else begin
      if (load) begin
        for (int i = 0; i < NENT; i++) work_q[i] <= stage_q[i];
      end
      if (wr_ok) stage_q[wr_addr] <= wr_data;
    end
  end

  assign rd_data = work_q[rd_addr];

endmodule

// File: rtl/eq_delay_store.sv
module eq_delay_store #(
  parameter int SECTIONS = 7,
  parameter int DATA_W   = 32,
  parameter int SEC_W    = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     upd,
  input  logic                     ch,
  input  logic [SEC_W-1:0]         sec,
  input  logic signed [DATA_W-1:0] x_new,
  input  logic signed [DATA_W-1:0] y_new,
  output logic signed [DATA_W-1:0] x_d1,
  output logic signed [DATA_W-1:0] x_d2,
  output logic signed [DATA_W-1:0] y_d1,
  output logic signed [DATA_W-1:0] y_d2
);
  localparam int NENT = 2 * SECTIONS;
  localparam int AW   = $clog2(NENT);

  logic signed [DATA_W-1:0] hx1 [NENT];
  logic signed [DATA_W-1:0] hx2 [NENT];
  logic signed [DATA_W-1:0] hy1 [NENT];
  logic signed [DATA_W-1:0] hy2 [NENT];
  logic [AW-1:0] addr;

  assign addr = AW'(int'(ch) * SECTIONS + int'(sec));

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NENT; i++) begin
        hx1[i] <= '0;
        hx2[i] <= '0;
        hy1[i] <= '0;
        hy2[i] <= '0;
      end
    end else if (upd) begin
      hx2[addr] <= hx1[addr];
      hx1[addr] <= x_new;
      hy2[addr] <= hy1[addr];
      hy1[addr] <= y_new;
    end
  end

  assign x_d1 = hx1[addr];
  assign x_d2 = hx2[addr];
  assign y_d1 = hy1[addr];
  assign y_d2 = hy2[addr];

endmodule

// File: rtl/eq_mac.sv
module eq_mac #(
  parameter int DATA_W    = 32,
  parameter int COEF_W    = 24,
  parameter int COEF_FRAC = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     clr,
  input  logic                     en,
  input  logic                     sub,
  input  logic signed [DATA_W-1:0] opnd,
  input  logic signed [COEF_W-1:0] coef,
  output logic signed [DATA_W-1:0] y
);
  localparam int PW   = DATA_W + COEF_W;
  localparam int ACCW = PW + 3;
  localparam logic signed [ACCW-1:0] HALF = ACCW'(64'sd1 <<< (COEF_FRAC - 1));
  localparam logic signed [DATA_W-1:0] POS_LIM = {1'b0, {(DATA_W-1){1'b1}}};
  localparam logic signed [DATA_W-1:0] NEG_LIM = {1'b1, {(DATA_W-1){1'b0}}};

  logic signed [PW-1:0]   prod;
  logic signed [ACCW-1:0] prod_x;
  logic signed [ACCW-1:0] acc;
  logic signed [ACCW-1:0] rnd;
  logic signed [ACCW-1:0] shf;
  logic [ACCW-DATA_W:0]   top_bits;

  assign prod   = PW'(opnd) * PW'(coef);
  assign prod_x = ACCW'(prod);

  always_ff @(posedge clk) begin
    if (rst || clr) acc <= '0;
    else if (en)    acc <= sub ? (acc - prod_x) : (acc + prod_x);
  end

  assign rnd      = acc + HALF;
  assign shf      = rnd >>> COEF_FRAC;
  assign top_bits = shf[ACCW-1:DATA_W-1];

  always_comb begin
    if ((&top_bits) || ~(|top_bits)) y = shf[DATA_W-1:0];
    else if (shf[ACCW-1])            y = NEG_LIM;
    else                             y = POS_LIM;
  end

endmodule

// File: rtl/stereo_biquad_eq.sv
module stereo_biquad_eq
  import eq_pkg::*;
#(
  parameter int SECTIONS  = 7,
  parameter int DATA_W    = 32,
  parameter int COEF_W    = 24,
  parameter int COEF_FRAC = 20,
  parameter int SEC_W     = $clog2(SECTIONS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              smp_stb,
  input  logic [DATA_W-1:0] smp_l,
  input  logic [DATA_W-1:0] smp_r,
  input  logic              bypass,
  input  logic              cfg_we,
  input  logic              cfg_ch,
  input  logic [SEC_W-1:0]  cfg_sect,
  input  logic [2:0]        cfg_idx,
  input  logic [COEF_W-1:0] cfg_coef,
  output logic              done,
  output logic [DATA_W-1:0] out_l,
  output logic [DATA_W-1:0] out_r
);
  logic                     busy;
  logic                     ch;
  logic [SEC_W-1:0]         sec;
  tap_e                     tap;
  logic signed [DATA_W-1:0] cur;
  logic signed [DATA_W-1:0] hold_r;
  logic signed [DATA_W-1:0] res_l;

  logic accept, run_start, fin, last_sec;
  logic signed [COEF_W-1:0] coef;
  logic signed [DATA_W-1:0] opnd, y_sec;
  logic signed [DATA_W-1:0] x_d1, x_d2, y_d1, y_d2;
  logic [2:0] rd_idx;

  assign accept    = smp_stb && !busy;
  assign run_start = accept && !bypass;
  assign fin       = busy && (tap == TAP_FIN);
  assign last_sec  = (int'(sec) == SECTIONS - 1);
  assign rd_idx    = (tap == TAP_FIN) ? 3'd0 : 3'(tap);

  eq_coef_bank #(
    .SECTIONS(SECTIONS), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC), .SEC_W(SEC_W)
  ) u_coef (
    .clk(clk), .rst(rst),
    .wr_en(cfg_we), .wr_ch(cfg_ch), .wr_sec(cfg_sect), .wr_idx(cfg_idx), .wr_data(cfg_coef),
    .load(accept),
    .rd_ch(ch), .rd_sec(sec), .rd_idx(rd_idx), .rd_data(coef)
  );

  eq_delay_store #(
    .SECTIONS(SECTIONS), .DATA_W(DATA_W), .SEC_W(SEC_W)
  ) u_hist (
    .clk(clk), .rst(rst), .upd(fin), .ch(ch), .sec(sec),
    .x_new(cur), .y_new(y_sec),
    .x_d1(x_d1), .x_d2(x_d2), .y_d1(y_d1), .y_d2(y_d2)
  );

  always_comb begin
    unique case (tap)
      TAP_B1:  opnd = x_d1;
      TAP_B2:  opnd = x_d2;
      TAP_A1:  opnd = y_d1;
      TAP_A2:  opnd = y_d2;
      default: opnd = cur;
    endcase
  end

  eq_mac #(
    .DATA_W(DATA_W), .COEF_W(COEF_W), .COEF_FRAC(COEF_FRAC)
  ) u_mac (
    .clk(clk), .rst(rst),
    .clr(run_start || fin),
    .en(busy && (tap != TAP_FIN)),
    .sub(tap_is_feedback(tap)),
    .opnd(opnd), .coef(coef), .y(y_sec)
  );

  // sequencer: left chain sections 0..N-1, then right chain, one tap per cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      busy   <= 1'b0;
      ch     <= 1'b0;
      sec    <= '0;
      tap    <= TAP_B0;
      cur    <= '0;
      hold_r <= '0;
      res_l  <= '0;
      done   <= 1'b0;
      out_l  <= '0;
      out_r  <= '0;
    end else begin
      done <= 1'b0;
      if (accept && bypass) begin
        out_l <= smp_l;
        out_r <= smp_r;
        done  <= 1'b1;
      end else if (run_start) begin
        busy   <= 1'b1;
        ch     <= 1'b0;
        sec    <= '0;
        tap    <= TAP_B0;
        cur    <= smp_l;
        hold_r <= smp_r;
      end else if (busy) begin
        if (tap != TAP_FIN) begin
          tap <= tap_e'(tap + 3'd1);
        end else begin
          tap <= TAP_B0;
          cur <= y_sec;
          if (!last_sec) begin
            sec <= sec + 1'b1;
          end else begin
            sec <= '0;
            if (!ch) begin
              ch    <= 1'b1;
              res_l <= y_sec;
              cur   <= hold_r;
            end else begin
              busy  <= 1'b0;
              out_l <= res_l;
              out_r <= y_sec;
              done  <= 1'b1;
            end
          end
        end
      end
    end
  end

endmodule

// File: rtl/eq_checks.sv
module eq_checks #(
  parameter int DATA_W = 32,
  parameter int LAT    = 84
) (
  input logic              clk,
  input logic              rst,
  input logic              smp_stb,
  input logic              bypass,
  input logic [DATA_W-1:0] smp_l,
  input logic [DATA_W-1:0] smp_r,
  input logic              busy,
  input logic              done,
  input logic [DATA_W-1:0] out_l,
  input logic [DATA_W-1:0] out_r
);
  localparam int CW = $clog2(LAT + 1);
  logic [CW-1:0] run_cnt;

  always_ff @(posedge clk) begin
    if (rst || !busy) run_cnt <= '0;
    else              run_cnt <= run_cnt + 1'b1;
  end

  // R1: the first cycle out of reset is idle with no result
  a_r1_idle_after_reset: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!done && !busy));

  // R5: bypass copies the pair on the next edge
  a_r5_bypass_pass: assert property (@(posedge clk) disable iff (rst)
    (smp_stb && bypass && !busy) |=> (done && out_l == $past(smp_l) && out_r == $past(smp_r)));

  // R4: outputs move only together with done
  a_r4_out_hold: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(out_l) && $stable(out_r)));

  // R4: a computation lasts exactly LAT edges and ends with done
  a_r4_latency: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (done && $past(run_cnt) == CW'(LAT - 1)));

  // R8: a computation starts only from an accepted, non-bypass strobe
  a_r8_start_idle: assert property (@(posedge clk) disable iff (rst)
    $rose(busy) |-> ($past(smp_stb) && !$past(bypass)));

endmodule

bind stereo_biquad_eq eq_checks #(
  .DATA_W(DATA_W), .LAT(2 * SECTIONS * 6)
) u_eq_checks (
  .clk(clk), .rst(rst), .smp_stb(smp_stb), .bypass(bypass),
  .smp_l(smp_l), .smp_r(smp_r), .busy(busy), .done(done),
  .out_l(out_l), .out_r(out_r)
);

// File: tb/test_stereo_biquad_eq.sv
`timescale 1ns/1ps
module test_stereo_biquad_eq;
  localparam int SECT = 7;
  localparam int NT   = 5;
  localparam int LAT  = 2 * SECT * 6;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic d_stb = 1'b0, d_byp = 1'b0;
  logic [31:0] d_l = '0, d_r = '0;
  logic we = 1'b0, wch = 1'b0;
  logic [2:0] wsec = '0, widx = '0;
  logic [23:0] wdat = '0;
  logic done;
  logic [31:0] out_l, out_r;

  int checks = 0;
  int fails = 0;
  string cur_req = "R1";

  always #2.5 clk = ~clk;

  stereo_biquad_eq i_stereo_biquad_eq (
    .clk(clk), .rst(rst), .smp_stb(d_stb), .smp_l(d_l), .smp_r(d_r), .bypass(d_byp),
    .cfg_we(we), .cfg_ch(wch), .cfg_sect(wsec), .cfg_idx(widx), .cfg_coef(wdat),
    .done(done), .out_l(out_l), .out_r(out_r)
  );

  // ---------------- behavioural reference ----------------
  logic signed [23:0] m_stage [2][SECT][NT];
  logic signed [23:0] m_work  [2][SECT][NT];
  longint m_x1 [2][SECT];
  longint m_x2 [2][SECT];
  longint m_y1 [2][SECT];
  longint m_y2 [2][SECT];
  bit m_busy = 0, m_done = 0;
  int m_cnt = 0;
  logic [31:0] m_out_l = '0, m_out_r = '0, m_res_l = '0, m_res_r = '0;

  function automatic longint clamp32(longint v);
    longint hi = 64'sd2147483647;
    longint lo = -64'sd2147483648;
    if (v > hi) return hi;
    if (v < lo) return lo;
    return v;
  endfunction

  function automatic longint run_chan(int c, longint xin);
    longint v = xin;
    for (int s = 0; s < SECT; s++) begin
      longint acc, y;
      acc = longint'(m_work[c][s][0]) * v
          + longint'(m_work[c][s][1]) * m_x1[c][s]
          + longint'(m_work[c][s][2]) * m_x2[c][s]
          - longint'(m_work[c][s][3]) * m_y1[c][s]
          - longint'(m_work[c][s][4]) * m_y2[c][s];
      y = clamp32((acc + 64'sd524288) >>> 20);
      m_x2[c][s] = m_x1[c][s]; m_x1[c][s] = v;
      m_y2[c][s] = m_y1[c][s]; m_y1[c][s] = y;
      v = y;
    end
    return v;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      for (int c = 0; c < 2; c++)
        for (int s = 0; s < SECT; s++) begin
          m_x1[c][s] = 0; m_x2[c][s] = 0; m_y1[c][s] = 0; m_y2[c][s] = 0;
          for (int k = 0; k < NT; k++) begin
            m_stage[c][s][k] = (k == 0) ? 24'sh100000 : 24'sh0;
            m_work[c][s][k]  = (k == 0) ? 24'sh100000 : 24'sh0;
          end
        end
      m_busy = 0; m_done = 0; m_cnt = 0;
      m_out_l = '0; m_out_r = '0;
    end else begin
      m_done = 0;
      if (m_busy) begin
        m_cnt++;
        if (m_cnt == LAT) begin
          m_busy = 0; m_done = 1; m_out_l = m_res_l; m_out_r = m_res_r;
        end
      end else if (d_stb) begin
        m_work = m_stage;
        if (d_byp) begin
          m_done = 1; m_out_l = d_l; m_out_r = d_r;
        end else begin
          m_busy = 1; m_cnt = 0;
          m_res_l = 32'(run_chan(0, longint'($signed(d_l))));
          m_res_r = 32'(run_chan(1, longint'($signed(d_r))));
        end
      end
      if (we && wsec < 3'd7 && widx < 3'd5) m_stage[wch][wsec][widx] = wdat;
    end
  end

  // cycle-by-cycle comparison against the reference
  always @(negedge clk) begin
    if (!rst) begin
      checks++;
      if (done !== m_done || (m_done && (out_l !== m_out_l || out_r !== m_out_r))) begin
        fails++;
        $display("FAIL %s cycle compare: done=%0b out=%h/%h expected done=%0b out=%h/%h",
                 cur_req, done, out_l, out_r, m_done, m_out_l, m_out_r);
      end
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic chk(string req, string what, logic [31:0] got, logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s: got %h expected %h", req, what, got, exp);
    end
  endtask

  task automatic put(logic [31:0] l, logic [31:0] r, logic b);
    @(negedge clk);
    d_l = l; d_r = r; d_byp = b; d_stb = 1'b1;
    @(negedge clk);
    d_stb = 1'b0; d_byp = 1'b0;
  endtask

  task automatic wr(logic c, logic [2:0] s, logic [2:0] k, logic [23:0] v);
    @(negedge clk);
    we = 1'b1; wch = c; wsec = s; widx = k; wdat = v;
    @(negedge clk);
    we = 1'b0;
  endtask

  task automatic wait_done();
    int n = 0;
    while (done !== 1'b1 && n < 400) begin
      @(negedge clk);
      n++;
    end
  endtask

  task automatic pair(string req, logic [31:0] l, logic [31:0] r, logic b,
                      logic [31:0] el, logic [31:0] er);
    cur_req = req;
    put(l, r, b);
    wait_done();
    chk(req, "left", out_l, el);
    chk(req, "right", out_r, er);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R4 watchdog: done count 0 expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5) @(negedge clk);
    rst = 1'b0;
    // R1 reset state and identity coefficients
    chk("R1", "done after reset", {31'd0, done}, 32'd0);
    chk("R1", "out_l after reset", out_l, 32'd0);
    chk("R1", "out_r after reset", out_r, 32'd0);
    pair("R1", 32'd1000, -32'sd2000, 1'b0, 32'd1000, -32'sd2000);

    // R7 out-of-range writes would alias real coefficients if accepted
    cur_req = "R7";
    wr(1'b0, 3'd7, 3'd0, 24'h0);
    wr(1'b0, 3'd0, 3'd5, 24'h0);
    pair("R7", 32'd77, -32'sd55, 1'b0, 32'd77, -32'sd55);

    // R2 rounding of ties: 0.5 * 3 -> 2, 0.5 * -3 -> -1
    cur_req = "R2";
    wr(1'b0, 3'd0, 3'd0, 24'h080000);
    pair("R2", 32'd3, -32'sd3, 1'b0, 32'd2, -32'sd3);
    pair("R2", -32'sd3, 32'd5, 1'b0, -32'sd1, 32'd5);

    // R6 write during computation affects only the following sample
    cur_req = "R6";
    put(32'd100, 32'd100, 1'b0);
    repeat (5) @(negedge clk);
    wr(1'b1, 3'd3, 3'd0, 24'h200000);
    wait_done();
    chk("R6", "left while writing", out_l, 32'd50);
    chk("R6", "right while writing", out_r, 32'd100);
    pair("R6", 32'd100, 32'd100, 1'b0, 32'd50, 32'd200);

    // R5 bypass
    pair("R5", 32'd123456, -32'sd7, 1'b1, 32'd123456, -32'sd7);

    // R9 saturation both directions
    cur_req = "R9";
    wr(1'b0, 3'd0, 3'd0, 24'h7FFFFF);
    wr(1'b1, 3'd3, 3'd0, 24'h800000);
    pair("R9", 32'h40000000, 32'h40000000, 1'b0, 32'h7FFFFFFF, 32'h80000000);

    // R8 strobe while busy ignored
    cur_req = "R8";
    wr(1'b0, 3'd0, 3'd0, 24'h100000);
    wr(1'b1, 3'd3, 3'd0, 24'h100000);
    put(32'd5, 32'd6, 1'b0);
    repeat (10) @(negedge clk);
    put(32'd999, 32'd999, 1'b0);
    wait_done();
    chk("R8", "left", out_l, 32'd5);
    chk("R8", "right", out_r, 32'd6);
    begin
      int extra = 0;
      for (int n = 0; n < 120; n++) begin
        @(negedge clk);
        if (done === 1'b1) extra++;
      end
      chk("R8", "extra done pulses", 32'(extra), 32'd0);
    end

    // R1 second reset, then R3 cascaded IIR with distinct per-channel sets
    cur_req = "R1";
    do_reset();
    chk("R1", "out_l after second reset", out_l, 32'd0);
    cur_req = "R3";
    wr(1'b0, 3'd1, 3'd0, 24'h040000);
    wr(1'b0, 3'd1, 3'd1, 24'h080000);
    wr(1'b0, 3'd1, 3'd2, 24'h040000);
    wr(1'b0, 3'd1, 3'd3, 24'hECCCCD);
    wr(1'b0, 3'd1, 3'd4, 24'h080000);
    wr(1'b0, 3'd5, 3'd0, 24'h200000);
    wr(1'b1, 3'd4, 3'd0, 24'h0C0000);
    wr(1'b1, 3'd4, 3'd1, 24'hF40000);
    wr(1'b1, 3'd4, 3'd3, 24'hF33333);
    for (int i = 0; i < 16; i++) begin
      logic [31:0] xl, xr;
      xl = (i == 0) ? 32'h01000000 : 32'(i * 40000 - 300000);
      xr = (i == 2) ? 32'hFF000000 : 32'(70000 - i * 9000);
      if (i == 7) begin
        cur_req = "R5";
        put(32'h12345678, 32'h0BADF00D, 1'b1);
        cur_req = "R3";
      end
      put(xl, xr, 1'b0);
      wait_done();
    end
    repeat (10) @(negedge clk);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule